// File: doc/BRIEF.md
# Mesh Router Output-Port Selector with Selectable Turn Rules

This unit decides, for one router of a two-dimensional mesh, which output port a packet header leaves by. A request carries the router's own column and row, the destination column and row, the input port the packet came in on, a rule-set select and one congestion flag per neighbour output. The unit builds the set of minimal moves allowed by the chosen turn rule set. It then grants exactly one port from the five: East, West, North, South and Local.

Requests enter over a valid/ready handshake and the decision leaves one cycle later over a second valid/ready handshake. The unit holds one result. A new request is taken when the output stage is empty or is being drained in the same cycle. While `out_ready` is low, a pending result stays fixed and `in_ready` is low. The rule-set select and the congestion flags count as part of the request and are sampled when it is accepted.

East is increasing column, North is increasing row. Buffers, arbitration and switching are outside the unit.

Top module: `route_unit`

## Requirements
- R1: After reset `out_valid` is low.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and its decision appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_port` and `out_valid` hold. `out_port` is one-hot whenever `out_valid` is high. Bit order is 0 East, 1 West, 2 North, 3 South, 4 Local.
- R3: When the current position equals the destination, Local (bit 4) is granted in every rule set.
- R4: Only productive (distance-reducing) directions are granted. East means destination column > current column. North means destination row > current row.
- R5: Rule set 0 (and the unused codes 6 and 7) route along X while the columns differ, and then along Y.
- R6: Rule set 1 grants West alone whenever West is productive. Otherwise any productive direction is allowed.
- R7: Rule set 2 excludes North while any other productive direction remains.
- R8: Rule set 3 allows only the productive negative directions (West, South) when at least one exists. Otherwise any productive direction is allowed.
- R9: Rule set 4 applies column-parity rules. The input port code is 0 East, 1 West, 2 North, 3 South, 4 Local. In an even column, a packet that came in on the West port (travelling east) may not take North or South while East is productive. In an odd column, a packet that came in on North or South may not take West while another productive direction remains.
- R10: Rule set 5 uses the rule-set-4 rules when at least `CONG_THRESH` (default 2) of the four congestion flags are set, and the rule-set-0 rules otherwise.
- R11: Among allowed ports, those whose congestion flag (bit 0 East, 1 West, 2 North, 3 South) is clear are preferred. Ties go in the order East, West, North, South.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| cur_x | input | X_W | Current column |
| cur_y | input | Y_W | Current row |
| dst_x | input | X_W | Destination column |
| dst_y | input | Y_W | Destination row |
| in_port | input | 3 | Input port the packet arrived on |
| mode | input | 3 | Turn rule set |
| cong_flags | input | 4 | Per-output congestion flags |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes decision |
| out_port | output | 5 | One-hot granted output port |

## Verification
Draining a held decision and accepting a new request can fall on the same edge. The bench stalls the output with `out_ready` low and presents a second request, which must see `in_ready` low and the first decision unchanged. It then raises `out_ready` while the second request is still offered. The decision seen after that edge must be the second request's, so neither request is lost or duplicated. Randomised requests over all rule sets are judged against a bench reference model of the rules.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int NPORT = 5;
  localparam int PE = 0;
  localparam int PW = 1;
  localparam int PN = 2;
  localparam int PS = 3;
  localparam int PL = 4;
  typedef enum logic [2:0] {
    RS_XY  = 3'd0,
    RS_WF  = 3'd1,
    RS_NL  = 3'd2,
    RS_NF  = 3'd3,
    RS_OE  = 3'd4,
    RS_DYN = 3'd5
  } rule_set_e;
endpackage

// File: rtl/load_gauge.sv
module load_gauge #(
  parameter int NFLAG = 4,
  parameter int THRESH = 2
) (
  input  logic [NFLAG-1:0] flags,
  output logic             busy
);
  localparam int CW = $clog2(NFLAG + 1);
  logic [CW-1:0] part [NFLAG+1];
  assign part[0] = '0;
  for (genvar i = 0; i < NFLAG; i++) begin : g_cnt
    assign part[i+1] = part[i] + CW'(flags[i]);
  end
  assign busy = (int'(part[NFLAG]) >= THRESH);
endmodule

// File: rtl/turn_filter.sv
module turn_filter
  import route_pkg::*;
#(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input  logic [X_W-1:0]   cur_x,
  input  logic [Y_W-1:0]   cur_y,
  input  logic [X_W-1:0]   dst_x,
  input  logic [Y_W-1:0]   dst_y,
  input  logic [2:0]       in_port,
  input  logic [2:0]       mode,
  input  logic             busy,
  output logic [NPORT-1:0] allow
);
  logic [NPORT-1:0] prod, m_xy, m_oe, m_wf, m_nl, m_nf, others;
  logic go_e, go_w, go_n, go_s, mov_e, mov_ns;

  always_comb begin
    go_e = dst_x > cur_x;
    go_w = dst_x < cur_x;
    go_n = dst_y > cur_y;
    go_s = dst_y < cur_y;
    prod = '0;
    prod[PE] = go_e;
    prod[PW] = go_w;
    prod[PN] = go_n;
    prod[PS] = go_s;

    m_xy = prod;
    if (go_e || go_w) begin
      m_xy[PN] = 1'b0;
      m_xy[PS] = 1'b0;
    end

    mov_e  = (in_port == 3'd1);
    mov_ns = (in_port == 3'd2) || (in_port == 3'd3);
    m_oe = prod;
    if (!cur_x[0] && mov_e && prod[PE]) begin
      m_oe[PN] = 1'b0;
      m_oe[PS] = 1'b0;
    end
    others = m_oe;
    others[PW] = 1'b0;
    if (cur_x[0] && mov_ns && (others != '0)) m_oe[PW] = 1'b0;

    m_wf = prod;
    if (go_w) begin
      m_wf = '0;
      m_wf[PW] = 1'b1;
    end

    m_nl = prod;
    m_nl[PN] = 1'b0;
    if (m_nl == '0) m_nl = prod;

    m_nf = prod;
    if (go_w || go_s) begin
      m_nf[PE] = 1'b0;
      m_nf[PN] = 1'b0;
    end

    unique case (mode)
      RS_WF:   allow = m_wf;
      RS_NL:   allow = m_nl;
      RS_NF:   allow = m_nf;
      RS_OE:   allow = m_oe;
      RS_DYN:  allow = busy ? m_oe : m_xy;
      default: allow = m_xy;
    endcase

    if (prod == '0) begin
      allow = '0;
      allow[PL] = 1'b1;
    end
  end
endmodule

// File: rtl/port_pick.sv
module port_pick
  import route_pkg::*;
(
  input  logic [NPORT-1:0] allow,
  input  logic [3:0]       cong,
  output logic [NPORT-1:0] grant
);
  logic [3:0] pool;
  logic       done;
  always_comb begin
    pool = allow[3:0] & ~cong;
    if (pool == '0) pool = allow[3:0];
    grant = '0;
    done  = 1'b0;
    if (allow[PL]) begin
      grant[PL] = 1'b1;
      done = 1'b1;
    end
    for (int i = 0; i < 4; i++) begin
      if (!done && pool[i]) begin
        grant[i] = 1'b1;
        done = 1'b1;
      end
    end
  end
endmodule

// File: rtl/route_unit.sv
module route_unit
  import route_pkg::*;
#(
  parameter int X_W = 3,
  parameter int Y_W = 3,
  parameter int CONG_THRESH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [X_W-1:0] cur_x,
  input  logic [Y_W-1:0] cur_y,
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic [2:0]     in_port,
  input  logic [2:0]     mode,
  input  logic [3:0]     cong_flags,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [4:0]     out_port
);
  logic             busy;
  logic [NPORT-1:0] allow, grant;

  load_gauge #(.NFLAG(4), .THRESH(CONG_THRESH)) u_gauge (
    .flags(cong_flags), .busy(busy));

  turn_filter #(.X_W(X_W), .Y_W(Y_W)) u_filter (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .in_port(in_port), .mode(mode), .busy(busy), .allow(allow));

  port_pick u_pick (.allow(allow), .cong(cong_flags), .grant(grant));

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_port <= grant;
    end
  end
endmodule

// File: rtl/route_unit_chk.sv
module route_unit_chk #(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [X_W-1:0] cur_x,
  input logic [Y_W-1:0] cur_y,
  input logic [X_W-1:0] dst_x,
  input logic [Y_W-1:0] dst_y,
  input logic [2:0]     mode,
  input logic           out_valid,
  input logic           out_ready,
  input logic [4:0]     out_port
);
  logic take;
  assign take = in_valid && in_ready;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot(out_port)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_port)); // R2
  AST_ARRIVED_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_x == dst_x && cur_y == dst_y |=> out_valid && out_port[4]); // R3
  AST_NO_X_DETOUR: assert property (@(posedge clk) disable iff (!rst_n)
    take && cur_x == dst_x |=> !out_port[0] && !out_port[1]); // R4
  AST_X_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode == 3'd0 && cur_x != dst_x |=> out_port[0] || out_port[1]); // R5
  AST_WEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode == 3'd1 && dst_x < cur_x |=> out_port[1]); // R6
endmodule

bind route_unit route_unit_chk #(.X_W(X_W), .Y_W(Y_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y), .mode(mode),
  .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port));

// File: tb/tb_route_unit.sv
module tb_route_unit;
  localparam int CLK_P = 10;
  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [2:0] cur_x, cur_y, dst_x, dst_y, in_port, mode;
  logic [3:0] cong_flags;
  logic [4:0] out_port;
  int errors = 0, checks = 0;
  bit summary_done = 0;

  route_unit dut (.*);

  function automatic logic [4:0] model(input logic [2:0] cx, cy, dx, dy,
                                       input logic [2:0] ip, md,
                                       input logic [3:0] cg);
    logic [4:0] p, xy, oe, a;
    logic [3:0] pool;
    int md_eff;
    p = {1'b0, dy < cy, dy > cy, dx < cx, dx > cx};
    if (p == 5'd0) return 5'b10000;
    xy = (p[0] | p[1]) ? (p & 5'b00011) : p;
    oe = p;
    if (!cx[0] && ip == 3'd1 && p[0]) oe = oe & 5'b10011;
    if (cx[0] && (ip == 3'd2 || ip == 3'd3) && (oe & 5'b11101) != 0) oe[1] = 1'b0;
    md_eff = md;
    if (md == 3'd5) md_eff = ($countones(cg) >= 2) ? 4 : 0;
    case (md_eff)
      1: a = p[1] ? 5'b00010 : p;
      2: a = ((p & 5'b11011) != 0) ? (p & 5'b11011) : p;
      3: a = (p[1] | p[3]) ? (p & 5'b01010) : p;
      4: a = oe;
      default: a = xy;
    endcase
    pool = a[3:0] & ~cg;
    if (pool == 0) pool = a[3:0];
    for (int i = 0; i < 4; i++) if (pool[i]) return 5'(1 << i);
    return 5'b00000;
  endfunction

  task automatic judge(input bit ok, input string req,
                       input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] cx, cy, dx, dy, ip, md,
                       input logic [3:0] cg);
    cur_x = cx; cur_y = cy; dst_x = dx; dst_y = dy;
    in_port = ip; mode = md; cong_flags = cg; in_valid = 1'b1;
  endtask

  task automatic one(input logic [2:0] cx, cy, dx, dy, ip, md,
                     input logic [3:0] cg, input string req);
    logic [4:0] e;
    e = model(cx, cy, dx, dy, ip, md, cg);
    @(negedge clk);
    out_ready = 1'b1;
    drive(cx, cy, dx, dy, ip, md, cg);
    @(posedge clk); #1;
    in_valid = 1'b0;
    judge(out_valid && out_port == e, req, out_port, e);
  endtask

  task automatic finish_run;
    if (!summary_done) begin
      summary_done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [4:0] ea, eb;
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; out_ready = 1;
    drive(0, 0, 0, 0, 0, 0, 0); in_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    judge(!out_valid, "R1", {4'b0, out_valid}, 5'b0);
    @(negedge clk); rst_n = 1;

    one(3, 4, 3, 4, 1, 2, 4'hF, "R3");
    one(5, 5, 5, 5, 0, 5, 4'h0, "R3");
    one(2, 2, 2, 6, 0, 0, 4'h0, "R4");
    one(1, 1, 5, 6, 0, 0, 4'h1, "R5");
    one(4, 1, 2, 6, 0, 6, 4'h0, "R5");
    one(6, 1, 2, 6, 4, 1, 4'h2, "R6");
    one(2, 2, 5, 6, 4, 1, 4'h1, "R6");
    one(2, 2, 5, 6, 4, 2, 4'h1, "R7");
    one(2, 2, 2, 6, 4, 2, 4'h0, "R7");
    one(2, 6, 5, 1, 4, 3, 4'h0, "R8");
    one(6, 2, 1, 5, 4, 3, 4'h2, "R8");
    one(2, 2, 5, 6, 1, 4, 4'h1, "R9");
    one(3, 2, 1, 6, 3, 4, 4'h4, "R9");
    one(3, 2, 1, 2, 3, 4, 4'h0, "R9");
    one(2, 2, 5, 6, 1, 5, 4'h1, "R10");
    one(2, 2, 5, 6, 1, 5, 4'h3, "R10");
    one(3, 2, 5, 6, 0, 5, 4'h9, "R10");
    one(2, 2, 5, 6, 0, 4, 4'h1, "R11");
    one(2, 2, 5, 6, 0, 4, 4'h5, "R11");

    // R2: stall, second request waits, drain and accept on the same edge
    ea = model(1, 1, 4, 1, 0, 0, 0);
    eb = model(4, 4, 4, 1, 0, 0, 0);
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 1, 4, 1, 0, 0, 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    judge(out_valid && out_port == ea, "R2", out_port, ea);
    @(negedge clk);
    drive(4, 4, 4, 1, 0, 0, 0);
    #1;
    judge(!in_ready, "R2", {4'b0, in_ready}, 5'b0);
    @(posedge clk); #1;
    judge(out_valid && out_port == ea, "R2", out_port, ea);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    judge(in_ready, "R2", {4'b0, in_ready}, 5'b1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    judge(out_valid && out_port == eb, "R2", out_port, eb);
    @(posedge clk); #1;
    judge(!out_valid, "R2", {4'b0, out_valid}, 5'b0);

    for (int k = 0; k < 400; k++) begin
      one(3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
          3'($urandom_range(0, 4)), 3'($urandom), 4'($urandom),
          "R5 R6 R7 R8 R9 R10 R11 random");
    end
    finish_run();
  end
endmodule